// File: doc/BRIEF.md
# Register-Driven Chunky-to-Planar Converter

This peripheral turns a block of 32 packed 8-bit pixels into eight bitplane words. The host writes eight 32-bit words, four pixels each, to one data register. It then reads eight 32-bit words back from that same register, one word for each bitplane. One bus access moves one word, so the converter never stalls the host.

The block has two phases. In the fill phase it stores incoming words into a 256-bit buffer. The eighth write switches it to the drain phase. In the drain phase each read returns the next plane, taken from a fixed transposition of the buffer. A write during the drain phase ends the drain early and starts a new fill phase.

Top module: `chunky_plane_conv`

## Requirements
- R1: After reset the block is in the fill phase with no words stored, and `rdata` is zero.
- R2: In each written word, pixel 0 of the word is in bits 31:24, pixel 1 in 23:16, pixel 2 in 15:8 and pixel 3 in 7:0. Write number i (counting from 0) carries pixels 4i to 4i+3 of the block.
- R3: In plane word k, bit 31-n holds bit k of pixel n. Pixel 0, the leftmost pixel, therefore lands in the most significant bit.
- R4: The eighth write of a fill phase switches the block to the drain phase. Successive reads then return plane 0, plane 1 and so on up to plane 7, and each read advances by one plane.
- R5: The read that returns plane 7 puts the block back into the fill phase with no words stored. A ninth read returns zero.
- R6: A read during the fill phase returns zero and does not change the count of stored words.
- R7: A write during the drain phase drops the planes not yet read. That write becomes word 0 of a new fill phase.
- R8: `rdata` is zero unless `cs` and `rd` are high and `wr` is low. Strobes that arrive while `cs` is low change no state.
- R9: When `wr` and `rd` are both high with `cs`, the access is treated as a write and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the data register |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 32 | Chunky word, four pixels |
| rdata | output | 32 | Plane word during a drain read, zero otherwise |

## Verification
A word counter that is off by one moves every later word into the wrong pixel slot. It also makes the phase switch one write early or late, so the first read after the block returns a wrong plane value or a wrong zero. A read counter that does not advance or wrap shows up within one read, as a repeated plane or as data returned where a zero is expected. A lost abort shows up on the first read of the next block.

// File: rtl/chunky_plane_conv.sv
module chunky_plane_conv #(
  parameter int PIX_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int PPW    = WORD_W / PIX_W;
  localparam int NPIX   = WORD_W;
  localparam int NWORDS = NPIX / PPW;
  localparam int NPLANE = PIX_W;
  localparam int CNT_W  = $clog2(NWORDS);

  logic [WORD_W-1:0] word_q [NWORDS];
  logic [WORD_W-1:0] plane  [NPLANE];
  logic              draining_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic [CNT_W-1:0]  rcnt_q;

  wire do_wr = cs & wr;
  wire do_rd = cs & rd & ~wr;

  genvar k, n;
  generate
    for (k = 0; k < NPLANE; k++) begin : g_plane
      for (n = 0; n < NPIX; n++) begin : g_pix
        assign plane[k][NPIX-1-n] =
          word_q[n / PPW][WORD_W - PIX_W*((n % PPW) + 1) + k];
      end
    end
  endgenerate

  assign rdata = (do_rd && draining_q) ? plane[rcnt_q] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining_q <= 1'b0;
      wcnt_q     <= '0;
      rcnt_q     <= '0;
    end else if (do_wr) begin
      if (draining_q) begin
        word_q[0]  <= wdata;
        wcnt_q     <= CNT_W'(1);
        draining_q <= 1'b0;
      end else begin
        word_q[wcnt_q] <= wdata;
        wcnt_q         <= wcnt_q + 1'b1;
        if (wcnt_q == CNT_W'(NWORDS-1)) begin
          draining_q <= 1'b1;
          rcnt_q     <= '0;
        end
      end
    end else if (do_rd && draining_q) begin
      rcnt_q <= rcnt_q + 1'b1;
      if (rcnt_q == CNT_W'(NPLANE-1)) begin
        draining_q <= 1'b0;
        wcnt_q     <= '0;
      end
    end
  end
endmodule

// File: rtl/chunky_plane_conv_chk.sv
module chunky_plane_conv_chk #(
  parameter int CNT_W  = 3,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              wr,
  input logic              rd,
  input logic [WORD_W-1:0] rdata,
  input logic              draining,
  input logic [CNT_W-1:0]  wcnt,
  input logic [CNT_W-1:0]  rcnt
);
  localparam logic [CNT_W-1:0] LAST = '1;

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !draining && wcnt != LAST) |=> (!draining && wcnt == $past(wcnt) + 1'b1)); // R2

  AST_ENTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !draining && wcnt == LAST) |=> (draining && rcnt == '0)); // R4

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr && draining && rcnt != LAST) |=> (draining && rcnt == $past(rcnt) + 1'b1)); // R4

  AST_DRAIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr && draining && rcnt == LAST) |=> (!draining && wcnt == '0)); // R5

  AST_FILL_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr && !draining) |=> (!draining && $stable(wcnt))); // R6

  AST_FILL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!draining) |-> (rdata == '0)); // R6

  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && draining) |=> (!draining && wcnt == CNT_W'(1))); // R7

  AST_NO_STROBE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs && rd) || wr) |-> (rdata == '0)); // R8

  AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs) |=> ($stable(draining) && $stable(wcnt) && $stable(rcnt))); // R8
endmodule

bind chunky_plane_conv chunky_plane_conv_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .rdata(rdata),
  .draining(draining_q), .wcnt(wcnt_q), .rcnt(rcnt_q)
);

// File: tb/chunky_plane_conv_tb.sv
module chunky_plane_conv_tb;
  localparam int PERIOD = 10;
  localparam int NBLK = 3;
  localparam logic [31:0] VEC [NBLK*8] = '{
    32'h00010203, 32'h04050607, 32'h08090A0B, 32'h0C0D0E0F,
    32'h10111213, 32'h14151617, 32'h18191A1B, 32'h1C1D1E1F,
    32'hAC3F9012, 32'h7E01C855, 32'hFF00A5E3, 32'h5A6B7C8D,
    32'h13579BDF, 32'h2468ACE0, 32'h80407F01, 32'hDEADBEEF,
    32'h01010101, 32'h01010101, 32'h01010101, 32'h01010101,
    32'h01010101, 32'h01010101, 32'h01010101, 32'h01010101
  };

  logic clk = 0, rst_n = 0, cs = 0, wr = 0, rd = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int errors = 0, checks = 0;
  logic done = 0;

  chunky_plane_conv u_dut (.clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd),
                           .wdata(wdata), .rdata(rdata));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ref_plane(input logic [31:0] w [8], input int k);
    logic [31:0] r;
    r = '0;
    for (int n = 0; n < 32; n++) begin
      logic [7:0] px;
      px = w[n/4][31-8*(n%4) -: 8];
      r[31-n] = px[k];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] w);
    @(negedge clk); cs = 1; wr = 1; rd = 0; wdata = w;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic do_read(output logic [31:0] v);
    @(negedge clk); cs = 1; rd = 1; wr = 0;
    #1 v = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic read_block(input string req, input logic [31:0] w [8]);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      do_read(v);
      check(req, v, ref_plane(w, k));
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD*20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] blk [8];
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R1 rdata after reset", rdata, 32'h0);
    do_read(v);
    check("R1 fill phase read", v, 32'h0);

    // table walk: R2 R3 R4 R5
    for (int b = 0; b < NBLK; b++) begin
      for (int i = 0; i < 8; i++) begin
        blk[i] = VEC[b*8+i];
        do_write(blk[i]);
      end
      read_block("R3 R4 plane order", blk);
      do_read(v);
      check("R5 ninth read", v, 32'h0);
    end

    // directed known block: all pixels 1 -> plane0 all ones (R2 R3)
    for (int i = 0; i < 8; i++) do_write(32'h01010101);
    do_read(v); check("R3 plane0 known", v, 32'hFFFFFFFF);
    do_read(v); check("R3 plane1 known", v, 32'h00000000);
    // abort mid drain: R7
    for (int i = 0; i < 8; i++) begin blk[i] = VEC[8+((i*3)%16)] ^ 32'h5A5A0F0F; end
    do_write(blk[0]);
    for (int i = 1; i < 8; i++) do_write(blk[i]);
    read_block("R7 block after abort", blk);

    // pixel 0 only: bit pattern AC -> planes show bit 31 per set bit (R2 R3)
    for (int i = 0; i < 8; i++) blk[i] = (i == 0) ? 32'hAC000000 : 32'h0;
    for (int i = 0; i < 8; i++) do_write(blk[i]);
    do_read(v); check("R3 pixel0 bit0", v, 32'h0);
    do_read(v); check("R3 pixel0 bit1", v, 32'h0);
    do_read(v); check("R3 pixel0 bit2", v, 32'h80000000);

    // reads in fill phase ignored: R6
    for (int i = 0; i < 8; i++) blk[i] = VEC[i] ^ 32'hF0F0F0F0;
    for (int i = 0; i < 3; i++) do_write(blk[i]);
    do_read(v); check("R6 fill read zero", v, 32'h0);
    do_read(v); check("R6 fill read zero again", v, 32'h0);
    for (int i = 3; i < 8; i++) do_write(blk[i]);
    do_read(v); check("R6 count kept plane0", v, ref_plane(blk, 0));

    // deselected strobes: R8
    @(negedge clk); cs = 0; rd = 1; wr = 0;
    #1 check("R8 rd without cs", rdata, 32'h0);
    @(negedge clk); wr = 1; wdata = 32'hFFFFFFFF;
    @(negedge clk); rd = 0; wr = 0;
    do_read(v); check("R8 drain not advanced", v, ref_plane(blk, 1));

    // simultaneous wr and rd in drain: R9 then R7
    for (int i = 0; i < 8; i++) blk[i] = VEC[16-i+7] + 32'h11111111 * i;
    @(negedge clk); cs = 1; wr = 1; rd = 1; wdata = blk[0];
    #1 check("R9 rdata zero on wr+rd", rdata, 32'h0);
    @(negedge clk); cs = 0; wr = 0; rd = 0;
    for (int i = 1; i < 8; i++) do_write(blk[i]);
    read_block("R9 write took effect", blk);

    // reset mid drain: R1
    for (int i = 0; i < 8; i++) do_write(VEC[i]);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    do_read(v); check("R1 reset clears drain", v, 32'h0);

    done = 1;
    finish_run();
  end
endmodule